// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Monitor

The monitor watches a 32-bit output-data word that drives a two-digit, time-multiplexed seven-segment display with decimal points. From that word it works out which segments of each digit are lit and presents them as two registered 8-bit patterns. It also presents a registered blank flag.

A one-cycle strobe marks every clock in which the word has changed in a way the display rules treat as visible. Logic that records or mirrors the display image can therefore sample the patterns only when the strobe fires.

The word is sampled on every rising clock edge. Patterns, the blank flag and the strobe all appear together one clock after the word that produced them. The monitor never drives the display, and it does not turn patterns back into characters.

Top module: `mseg_monitor`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, both patterns, the blank flag and the strobe are 0. The remembered previous word is cleared to all zeros, so the first word after reset is compared with zero.
- R2: Pattern bit order is {dp, g, f, e, d, c, b, a}, bit 7 down to bit 0. The word bits feeding them are: a = bit 25 (top), b = bit 24 (upper right), c = bit 22 (lower right), d = bit 21 (bottom), e = bit 20 (lower left), f = bit 27 (upper left), g = bit 26 (middle), dp = bit 23.
- R3: A segment of a digit is lit only when that digit's select bit is 0 and the segment bit is 1. The left digit select is bit 28 and the right digit select is bit 30. A digit whose select bit is 1 shows pattern 0.
- R4: When bit 31 (blank) is 1, the blank flag is 1 and both patterns are 0, whatever the segment and select bits are.
- R5: The strobe fires when any of bits 20..27 changed, at least one select bit is 0 in the new word, and blank is 0 in the new word.
- R6: The strobe fires when bit 28 or bit 30 changed and blank is 0 in the new word.
- R7: The strobe fires when bit 31 changed and at least one select bit is 0 in the new word.
- R8: Changes confined to bits 0..19 and bit 29 never fire the strobe. Segment changes while blank is 1, or while both selects are 1, do not fire it either. A blank change while both selects are 1 does not fire it.
- R9: The strobe is high for exactly one clock per changed word. It appears in the same cycle as the patterns computed from that word, one clock after the word is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| port_word | input | 32 | Output-data word driving the display |
| left_seg | output | 8 | Lit pattern of the left digit, {dp,g,f,e,d,c,b,a} |
| right_seg | output | 8 | Lit pattern of the right digit, {dp,g,f,e,d,c,b,a} |
| blank | output | 1 | Registered copy of the blank bit |
| upd | output | 1 | One-cycle strobe on a visible change |

## Verification
The hardest cases are the changes that must stay silent even though watched bits toggle. These are segment edits made while blank is set or while both digits are deselected, and a blank toggle made while both digits are deselected. Such states can only be reached through a sequence of words.

The vector table therefore walks through a chain of words. It first deselects both digits, then toggles blank and the segments there, and only then reselects a digit, which must fire the strobe.

A reset in the middle of the run then checks that the remembered word was cleared. After that reset a zero word must stay silent, and the next segment word must fire the strobe.

// File: rtl/mseg_pkg.sv
package mseg_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_DIGITS = 2;
    localparam int SEG_W      = 8;
    localparam int SEG_LSB    = 20;
    localparam int SEG_MSB    = SEG_LSB + SEG_W - 1;
    localparam int BLANK_POS  = 31;

    // digit select positions, index 0 = left, 1 = right (active low)
    localparam int SEL_POS [NUM_DIGITS] = '{28, 30};

    // lit pattern, MSB first
    typedef struct packed {
        logic dp;
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_pat_t;

    // fields of the word that matter for the visible image
    typedef struct packed {
        logic                  blank;
        logic [NUM_DIGITS-1:0] sel_n;
        logic [SEG_W-1:0]      lines;
    } view_t;

    // raw lines are word[27:20]; reorder into the pattern layout
    function automatic seg_pat_t map_lines(input logic [SEG_W-1:0] r);
        seg_pat_t p;
        p.e  = r[0];
        p.d  = r[1];
        p.c  = r[2];
        p.dp = r[3];
        p.b  = r[4];
        p.a  = r[5];
        p.g  = r[6];
        p.f  = r[7];
        return p;
    endfunction

endpackage

// File: rtl/mseg_digit_decode.sv
module mseg_digit_decode
    import mseg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEG_W-1:0] lines,
    input  logic             sel_n,
    input  logic             blank,
    output seg_pat_t         pat
);

    seg_pat_t pat_d;

    always_comb begin
        pat_d = map_lines(lines);
        if (sel_n || blank) begin
            pat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat <= '0;
        end else begin
            pat <= pat_d;
        end
    end

    // R3: a deselected digit shows nothing on the next cycle
    p_dark_when_deselected_r3: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (pat == '0));

    // R4: blank clears the digit on the next cycle
    p_dark_when_blank_r4: assert property (@(posedge clk) disable iff (rst)
        blank |=> (pat == '0));

endmodule

// File: rtl/mseg_change_detect.sv
module mseg_change_detect
    import mseg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  view_t cur,
    output logic  blank_q,
    output logic  upd
);

    view_t prev;
    view_t diff;
    logic  seg_chg;
    logic  sel_chg;
    logic  blk_chg;
    logic  any_sel;
    logic  upd_d;

    always_comb begin
        diff    = cur ^ prev;
        seg_chg = |diff.lines;
        sel_chg = |diff.sel_n;
        blk_chg = diff.blank;
        any_sel = ~&cur.sel_n;
        upd_d   = (seg_chg && any_sel && !cur.blank)
                | (sel_chg && !cur.blank)
                | (blk_chg && any_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            blank_q <= 1'b0;
            upd     <= 1'b0;
        end else begin
            prev    <= cur;
            blank_q <= cur.blank;
            upd     <= upd_d;
        end
    end

    // R9: an unchanged view cannot produce a strobe
    p_quiet_when_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (cur == prev) |=> !upd);

    // R5: a visible segment edit must be reported
    p_seg_edit_seen_r5: assert property (@(posedge clk) disable iff (rst)
        ((cur.lines != prev.lines) && !cur.blank && !(&cur.sel_n)) |=> upd);

    // R8: edits under blank with no select or blank change stay silent
    p_silent_under_blank_r8: assert property (@(posedge clk) disable iff (rst)
        (cur.blank && prev.blank && (cur.sel_n == prev.sel_n)) |=> !upd);

endmodule

// File: rtl/mseg_monitor.sv
module mseg_monitor
    import mseg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] port_word,
    output logic [SEG_W-1:0]  left_seg,
    output logic [SEG_W-1:0]  right_seg,
    output logic              blank,
    output logic              upd
);

    view_t    view;
    seg_pat_t pats [NUM_DIGITS];
    logic     unused_bits;

    assign unused_bits = ^{port_word[SEG_LSB-1:0], port_word[29]};

    always_comb begin
        view.lines = port_word[SEG_MSB:SEG_LSB];
        view.blank = port_word[BLANK_POS];
        for (int k = 0; k < NUM_DIGITS; k++) begin
            view.sel_n[k] = port_word[SEL_POS[k]];
        end
    end

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        mseg_digit_decode u_dec (
            .clk   (clk),
            .rst   (rst),
            .lines (view.lines),
            .sel_n (view.sel_n[d]),
            .blank (view.blank),
            .pat   (pats[d])
        );
    end

    mseg_change_detect u_chg (
        .clk     (clk),
        .rst     (rst),
        .cur     (view),
        .blank_q (blank),
        .upd     (upd)
    );

    assign left_seg  = pats[0];
    assign right_seg = pats[1];

    // R4: the blank flag and lit segments never coexist
    p_blank_means_dark_r4: assert property (@(posedge clk) disable iff (rst)
        blank |-> (left_seg == '0 && right_seg == '0));

    // R1: reset leaves every output low on the next cycle
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (left_seg == '0 && right_seg == '0 && !blank && !upd));

endmodule

// File: tb/mseg_monitor_tb.sv
`timescale 1ns/1ps
module mseg_monitor_tb;

    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] port_word = '0;
    logic [7:0]  left_seg;
    logic [7:0]  right_seg;
    logic        blank;
    logic        upd;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    mseg_monitor u_dut (
        .clk       (clk),
        .rst       (rst),
        .port_word (port_word),
        .left_seg  (left_seg),
        .right_seg (right_seg),
        .blank     (blank),
        .upd       (upd)
    );

    // {word, left, right, blank, upd}
    localparam logic [49:0] VEC [NV] = '{
        {32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b0}, // R1 zero after reset: no change
        {32'h0200_0000, 8'h01, 8'h01, 1'b0, 1'b1}, // R2 R5 top segment on both digits
        {32'h0200_0000, 8'h01, 8'h01, 1'b0, 1'b0}, // R9 held word: strobe drops
        {32'h0200_ABCD, 8'h01, 8'h01, 1'b0, 1'b0}, // R8 low bits only
        {32'h4200_ABCD, 8'h01, 8'h00, 1'b0, 1'b1}, // R3 R6 right deselected
        {32'h6200_ABCD, 8'h01, 8'h00, 1'b0, 1'b0}, // R8 bit 29 only
        {32'hE200_ABCD, 8'h00, 8'h00, 1'b1, 1'b1}, // R4 R7 blank on
        {32'hE600_ABCD, 8'h00, 8'h00, 1'b1, 1'b0}, // R8 segment edit under blank
        {32'h7600_ABCD, 8'h00, 8'h00, 1'b0, 1'b1}, // R6 unblank + left deselect
        {32'h7610_ABCD, 8'h00, 8'h00, 1'b0, 1'b0}, // R8 segment edit, both deselected
        {32'hF610_ABCD, 8'h00, 8'h00, 1'b1, 1'b0}, // R8 blank on, both deselected
        {32'h7610_ABCD, 8'h00, 8'h00, 1'b0, 1'b0}, // R8 blank off, both deselected
        {32'h6610_ABCD, 8'h51, 8'h00, 1'b0, 1'b1}, // R2 R6 left reselected: a,g,e
        {32'h6FF0_ABCD, 8'hFF, 8'h00, 1'b0, 1'b1}, // R5 all segments on left
        {32'h0FF0_0000, 8'hFF, 8'hFF, 1'b0, 1'b1}, // R3 R6 both selected
        {32'h0180_0000, 8'h82, 8'h82, 1'b0, 1'b1}, // R2 dp and b
        {32'h0060_0000, 8'h0C, 8'h0C, 1'b0, 1'b1}, // R2 c and d
        {32'h0800_0000, 8'h20, 8'h20, 1'b0, 1'b1}, // R2 f
        {32'h8800_0000, 8'h00, 8'h00, 1'b1, 1'b1}  // R4 R7 blank with both selected
    };

    task automatic check(input string req, input logic [7:0] el, input logic [7:0] er,
                         input logic eb, input logic eu);
        checks++;
        if (left_seg !== el || right_seg !== er || blank !== eb || upd !== eu) begin
            errors++;
            $display("FAIL %s: got left=%h right=%h blank=%b upd=%b, expected left=%h right=%h blank=%b upd=%b",
                     req, left_seg, right_seg, blank, upd, el, er, eb, eu);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs held low during reset
        repeat (3) @(negedge clk);
        port_word = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R1", 8'h00, 8'h00, 1'b0, 1'b0);
        port_word = '0;
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            port_word = VEC[i][49:18];
            @(negedge clk);
            check($sformatf("vector %0d", i), VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R1: mid-run reset clears outputs and the remembered word
        port_word = 32'h0FF0_0000;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset", 8'h00, 8'h00, 1'b0, 1'b0);
        port_word = '0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 zero vs cleared", 8'h00, 8'h00, 1'b0, 1'b0);
        port_word = 32'h0400_0000;
        @(negedge clk);
        check("R5 after reset", 8'h40, 8'h40, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 single pulse", 8'h40, 8'h40, 1'b0, 1'b0);

        finish_run();
    end

endmodule